// File: doc/BRIEF.md
# Fault Event Detector with Interrupt Request

This block watches for a fault condition on behalf of a PWM timer and turns it into a latched interrupt request. The trigger comes from one of two sources, chosen by a select input: a dedicated fault pin, or the output of an analog comparator. Whichever source is chosen passes through the same chain. That chain is a two-stage synchroniser, then an optional noise filter, then an edge detector that is set to react to either rising or falling transitions.

A detected edge sets a sticky fault flag. The interrupt request output is high only while three conditions hold together: the global interrupt enable is high, the local fault interrupt enable is high, and the flag is set. Software or the interrupt controller clears the flag in one of two ways. An acknowledge pulse from the interrupt controller clears it at the next clock edge. A software write of one clears it one clock later, because the write passes through one register stage. A write of zero has no effect.

If a new edge is detected in the same cycle that a clear takes effect, the edge wins and the flag stays set. The pin input is sampled regardless of the direction the pin has been given elsewhere on the chip, so a pin driven as an output still raises events. All interfaces are plain level or strobe signals, and there is no handshake.

Top module: `fpe_unit`

## Requirements
- R1: After reset, `flag_o` and `irq_o` are both 0.
- R2: With `src_sel_i` = 0 the fault pin is the trigger and the comparator input has no effect. With `src_sel_i` = 1 the comparator input is the trigger and the pin has no effect.
- R3: With the filter off, a qualifying edge on the selected input sets the flag as follows. Let the first rising clock edge that samples the new level be edge 1. `flag_o` reads 1 after edge 3 and still reads 0 after edge 2.
- R4: `edge_rise_i` = 1 selects detection of 0-to-1 transitions, and `edge_rise_i` = 0 selects 1-to-0 transitions. A transition in the other direction leaves the flag unchanged.
- R5: With `filt_en_i` = 1, a new level passes the filter only after it has been sampled 4 times in a row. This adds 4 cycles to the latency of R3, so the flag reads 1 after edge 7 and 0 after edge 6. A pulse lasting 3 cycles is rejected, and a pulse lasting 4 cycles is accepted.
- R6: Once set, the flag stays set until a clear occurs, whatever the input does.
- R7: `irq_o` is 1 exactly when `gie_i`, `fie_i` and `flag_o` are all 1.
- R8: An acknowledge pulse on `irq_ack_i` clears the flag at the clock edge that samples it.
- R9: A write strobe `clr_wr_i` with `clr_data_i` = 1 clears the flag one cycle after the edge that samples it. A strobe with `clr_data_i` = 0 leaves the flag unchanged.
- R10: When a detected edge and a clear (from an acknowledge or from a pending write of one) meet in the same cycle, the flag stays set.
- R11: A comparator-sourced event uses the same filter and the same edge selection as a pin-sourced event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fault_pin_i | input | 1 | Asynchronous fault pin level |
| cmp_out_i | input | 1 | Asynchronous comparator output |
| src_sel_i | input | 1 | Trigger source: 0 selects the pin, 1 selects the comparator |
| filt_en_i | input | 1 | 1 enables the 4-sample noise filter |
| edge_rise_i | input | 1 | 1 detects rising edges, 0 detects falling edges |
| gie_i | input | 1 | Global interrupt enable |
| fie_i | input | 1 | Local fault interrupt enable |
| clr_wr_i | input | 1 | Software write strobe for the flag bit |
| clr_data_i | input | 1 | Data bit of that write; 1 requests a clear |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| flag_o | output | 1 | Sticky fault flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can land on the same cycle: a newly detected edge setting the flag, and a clear removing it. The bench provokes this by counting the synchroniser stages. It drives the input transition, waits exactly two clock edges, and then raises the acknowledge so that it is sampled at the same edge where the edge detector fires. It repeats the collision with a write of one, issued one cycle earlier so that the delayed clear lands on that same edge. The flag is judged to have stayed set after the collision, and a lone acknowledge afterwards confirms that the clear path itself still works.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  typedef enum logic {
    SRC_PIN = 1'b0,
    SRC_CMP = 1'b1
  } fpe_src_e;

  localparam int FPE_SYNC_STAGES = 2;
  localparam int FPE_FILT_LEN    = 4;
endpackage

// File: rtl/fpe_sync.sv
module fpe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= 1'b0;
    else         chain_q[0] <= async_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b0;
      else         chain_q[g] <= chain_q[g-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/fpe_filter.sv
module fpe_filter #(
  parameter int LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic raw_i,
  output logic lvl_o
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] run_q;
  logic          held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      held_q <= 1'b0;
    end else if (raw_i == held_q) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      run_q  <= '0;
      held_q <= raw_i;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign lvl_o = en_i ? held_q : raw_i;
endmodule

// File: rtl/fpe_edge.sv
module fpe_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic rise_i,
  output logic evt_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  always_comb begin
    if (rise_i) evt_o = lvl_i & ~prev_q;
    else        evt_o = ~lvl_i & prev_q;
  end
endmodule

// File: rtl/fpe_flag.sv
module fpe_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic ack_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic flag_o
);
  logic wclr_q;
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wclr_q <= 1'b0;
    else         wclr_q <= wr_i & wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flag_q <= 1'b0;
    else if (evt_i)             flag_q <= 1'b1;
    else if (ack_i || wclr_q)   flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/fpe_unit.sv
module fpe_unit
  import fpe_pkg::*;
#(
  parameter int SYNC_STAGES = FPE_SYNC_STAGES,
  parameter int FILT_LEN    = FPE_FILT_LEN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_pin_i,
  input  logic cmp_out_i,
  input  logic src_sel_i,
  input  logic filt_en_i,
  input  logic edge_rise_i,
  input  logic gie_i,
  input  logic fie_i,
  input  logic clr_wr_i,
  input  logic clr_data_i,
  input  logic irq_ack_i,
  output logic flag_o,
  output logic irq_o
);
  fpe_src_e src_w;
  logic     raw_w;
  logic     sync_w;
  logic     lvl_w;
  logic     evt_w;

  assign src_w = fpe_src_e'(src_sel_i);
  assign raw_w = (src_w == SRC_CMP) ? cmp_out_i : fault_pin_i;

  fpe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(raw_w),
    .sync_o (sync_w)
  );

  fpe_filter #(.LEN(FILT_LEN)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (filt_en_i),
    .raw_i (sync_w),
    .lvl_o (lvl_w)
  );

  fpe_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl_w),
    .rise_i(edge_rise_i),
    .evt_o (evt_w)
  );

  fpe_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_w),
    .ack_i  (irq_ack_i),
    .wr_i   (clr_wr_i),
    .wdata_i(clr_data_i),
    .flag_o (flag_o)
  );

  assign irq_o = gie_i & fie_i & flag_o;
endmodule

// File: rtl/fpe_unit_chk.sv
module fpe_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic gie,
  input logic fie,
  input logic ack,
  input logic wr,
  input logic wdata,
  input logic evt,
  input logic flag,
  input logic irq
);
  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie || !fie) |-> !irq);

  a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);

  a_r6_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(evt));

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && ack && !evt) |=> !flag);

  a_r9_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata) ##1 !evt |=> !flag);

  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && ack) |=> flag);
endmodule

bind fpe_unit fpe_unit_chk u_chk (
  .clk  (clk_i),
  .rst_n(rst_ni),
  .gie  (gie_i),
  .fie  (fie_i),
  .ack  (irq_ack_i),
  .wr   (clr_wr_i),
  .wdata(clr_data_i),
  .evt  (evt_w),
  .flag (flag_o),
  .irq  (irq_o)
);

// File: tb/test_fpe_unit.sv
`timescale 1ns/1ps
module test_fpe_unit;
  logic clk = 1'b0;
  logic rst_n, pin, cmp, src, filt, rise, gie, fie, wr, wdata, ack;
  logic flag, irq;

  always #2.5 clk = ~clk;

  fpe_unit i_fpe_unit (
    .clk_i(clk), .rst_ni(rst_n), .fault_pin_i(pin), .cmp_out_i(cmp),
    .src_sel_i(src), .filt_en_i(filt), .edge_rise_i(rise), .gie_i(gie),
    .fie_i(fie), .clr_wr_i(wr), .clr_data_i(wdata), .irq_ack_i(ack),
    .flag_o(flag), .irq_o(irq)
  );

  typedef struct {
    string tag;
    logic  f;
    logic  i;
  } exp_t;

  exp_t q[$];
  event chk_ev;
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input string tag, input logic f, input logic i);
    exp_t e;
    e.tag = tag; e.f = f; e.i = i;
    q.push_back(e);
    -> chk_ev;
    #0.1;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; step(1); ack = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (flag !== e.f || irq !== e.i) begin
          n_fail++;
          $display("FAIL %s: flag=%b irq=%b expected flag=%b irq=%b",
                   e.tag, flag, irq, e.f, e.i);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 0; pin = 0; cmp = 0; src = 0; filt = 0; rise = 1;
    gie = 0; fie = 0; wr = 0; wdata = 0; ack = 0;
    step(3);
    expect_now("R1 reset", 1'b0, 1'b0);
    rst_n = 1; gie = 1; fie = 1;
    step(3);

    // R3 latency through synchroniser
    pin = 1; step(2);
    expect_now("R3 not yet after edge 2", 1'b0, 1'b0);
    step(1);
    expect_now("R3 set after edge 3", 1'b1, 1'b1);
    step(5);
    expect_now("R6 sticky", 1'b1, 1'b1);
    pulse_ack();
    expect_now("R8 ack clears", 1'b0, 1'b0);
    pin = 0; step(5);
    expect_now("R4 falling ignored in rising mode", 1'b0, 1'b0);

    // R7 gating
    pin = 1; step(3);
    gie = 0; step(1);
    expect_now("R7 gie low", 1'b1, 1'b0);
    gie = 1; fie = 0; step(1);
    expect_now("R7 fie low", 1'b1, 1'b0);
    fie = 1; step(1);
    expect_now("R7 all high", 1'b1, 1'b1);

    // R9 software clears
    wr = 1; wdata = 0; step(1); wr = 0; step(2);
    expect_now("R9 write zero ignored", 1'b1, 1'b1);
    wr = 1; wdata = 1; step(1); wr = 0; wdata = 0;
    expect_now("R9 clear still pending", 1'b1, 1'b1);
    step(1);
    expect_now("R9 write one clears", 1'b0, 1'b0);

    // R4 falling mode
    rise = 0; step(4);
    expect_now("R4 mode switch no event", 1'b0, 1'b0);
    pin = 0; step(2);
    expect_now("R4 falling not yet", 1'b0, 1'b0);
    step(1);
    expect_now("R4 falling detected", 1'b1, 1'b1);
    pulse_ack();
    pin = 1; step(5);
    expect_now("R4 rising ignored in falling mode", 1'b0, 1'b0);
    rise = 1; pin = 0; step(5);

    // R10 collisions
    pin = 1; step(3);
    expect_now("R10 prep set", 1'b1, 1'b1);
    pin = 0; step(5);
    pin = 1; step(2);
    ack = 1; step(1); ack = 0;
    expect_now("R10 event beats ack", 1'b1, 1'b1);
    pin = 0; step(5);
    pin = 1; step(1);
    wr = 1; wdata = 1; step(1); wr = 0; wdata = 0;
    step(1);
    expect_now("R10 event beats write clear", 1'b1, 1'b1);
    step(1);
    expect_now("R10 flag held after collision", 1'b1, 1'b1);
    pulse_ack();
    expect_now("R10 lone ack clears", 1'b0, 1'b0);

    // R2 source selection
    pin = 0; step(5);
    cmp = 1; step(5);
    expect_now("R2 comparator ignored on pin source", 1'b0, 1'b0);
    cmp = 0; step(5);
    src = 1; step(5);
    expect_now("R2 switch to comparator", 1'b0, 1'b0);
    cmp = 1; step(2);
    expect_now("R2 comparator not yet", 1'b0, 1'b0);
    step(1);
    expect_now("R2 comparator path sets", 1'b1, 1'b1);
    pulse_ack();
    pin = 1; step(5);
    expect_now("R2 pin ignored on comparator source", 1'b0, 1'b0);
    pin = 0; step(5);

    // R5 / R11 filter on comparator
    filt = 1; step(8);
    cmp = 0; step(8);
    expect_now("R11 comparator falling ignored with filter", 1'b0, 1'b0);
    cmp = 1; step(3); cmp = 0; step(8);
    expect_now("R5 R11 3-cycle pulse rejected", 1'b0, 1'b0);
    cmp = 1; step(6);
    expect_now("R5 filtered not yet after edge 6", 1'b0, 1'b0);
    step(1);
    expect_now("R5 R11 filtered set after edge 7", 1'b1, 1'b1);
    cmp = 0; step(8);
    pulse_ack();
    src = 0; step(8);
    expect_now("R5 pin source filter idle", 1'b0, 1'b0);
    pin = 1; step(4); pin = 0; step(10);
    expect_now("R5 4-cycle pulse accepted", 1'b1, 1'b1);

    step(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule